// File: doc/BRIEF.md
# Linked-Descriptor Plane Register Loader

This block keeps the register set of one graphics plane up to date from a chain of descriptor nodes in memory. A node is a block of sixteen 32-bit words, aligned to 16 bytes. Software places a pair of nodes in memory, one for each field, with each node's link word pointing at the other, and writes the address of the first node into the next-node register. On every vertical-sync pulse the block reads the node that register points to, word by word, through a single-outstanding read master. When the last word arrives, the node's link word becomes the new next-node address and the node's contents become the plane's active register set in one step.

A node whose control word has bit 31 set is held back after its fetch and takes effect only at the following vsync. A node whose plane-control word has either of its two low bits set hides the plane. A vsync that arrives while a fetch is still running raises a sticky late-fetch flag, and that node is thrown away. Software can read back the active registers, the next-node register and a status word over the register bus.

Top module: `plane_node_loader`

Node word layout (byte offset inside a node; the same offsets read back the active set): control 0x00 (bit 31 = defer to next vsync), alpha/gain 0x04, view origin 0x0C, view stop 0x10, pixel address 0x14, pitch 0x18, size 0x1C, link 0x24, key A 0x28, key B 0x2C, plane control 0x34 (bits 1:0 nonzero = hidden), palette address 0x3C. All other words are reserved. Status is at 0x68: bit 0 underflow, bit 1 late fetch, bit 2 misaligned pointer, bit 3 field level at the latest vsync.

## Requirements
- R1: After reset the active registers, the next-node register and the status word read as zero, memReq is low and planeShow is low.
- R2: On a vsync with a nonzero, 16-byte-aligned next-node value and no fetch running, the block requests the 16 node words one at a time at next-node + 4*k, for k from 0 up to 15.
- R3: The active registers and the exported active ports keep their previous values until the last node word has arrived, and then all change together.
- R4: When a fetch completes, word 9 (byte 0x24) of the node becomes the next-node value, so a linked pair of nodes is fetched in alternation.
- R5: A fetched node with control bit 31 clear becomes active as soon as its fetch completes. With bit 31 set it is held and becomes active at the next vsync.
- R6: planeShow is high only when an active set has been loaded and bits 1:0 of the active plane-control word (0x34) are both zero.
- R7: A vsync while the next-node register is zero starts no memory request.
- R8: A vsync while the next-node register has nonzero bits 3:0 starts no memory request and sets status bit 2.
- R9: A register-bus write to offset 0x24 replaces the next-node value, and the next vsync fetches from the written address.
- R10: A vsync that arrives while a fetch is running sets status bit 1 and starts no fetch. The node being fetched is discarded, so the active set and the next-node register stay unchanged.
- R11: A high underflow input sets status bit 0. Writing 1 to a status bit 2:0 at 0x68 clears that bit, and a set takes priority over a clear in the same cycle.
- R12: Status bit 3 holds the fieldTop level sampled at the most recent vsync.
- R13: Reads at the used node offsets return the active words, 0x24 returns the next-node value, 0x68 returns the status word, and every other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset for writes and reads |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| vsync | input | 1 | One-cycle vertical-sync pulse |
| fieldTop | input | 1 | Field level, 1 = top field |
| underflow | input | 1 | Pixel-buffer underflow indication |
| memReq | output | 1 | Read request, held until memRvalid |
| memAddr | output | ADDR_W | Byte address of the word requested |
| memRvalid | input | 1 | Read data valid for the current request |
| memRdata | input | 32 | Read data |
| planeShow | output | 1 | Plane may be displayed |
| actPixAddr | output | 32 | Active pixel memory address |
| actPitch | output | 32 | Active line pitch |
| actSize | output | 32 | Active source size |
| actOrigin | output | 32 | Active viewport origin |
| actStop | output | 32 | Active viewport stop |

## Verification
The bench goes after the node being applied part-way through. It samples the exported pixel address a few cycles into each fetch, when a design that writes words straight into the active set would already show the new value. It fires a second vsync in the middle of a fetch. A design that still committed that node, or followed its link, would show a changed register set or next-node value afterwards. Deferred nodes are checked both right after their fetch and after the next vsync, which catches a design that applies them early or drops them. Zero and misaligned pointers are checked to confirm that no request appears at all, which would expose a design that fetches from address zero or from a rounded-down address.

// File: rtl/plane_node_pkg.sv
`timescale 1ns/1ps
package plane_node_pkg;
  localparam int NODE_WORDS = 16;
  localparam int IDX_W      = $clog2(NODE_WORDS);

  // word positions inside a node (word index = byte offset / 4)
  localparam int W_CTL   = 0;
  localparam int W_PIX   = 5;
  localparam int W_PITCH = 6;
  localparam int W_SIZE  = 7;
  localparam int W_ORG   = 3;
  localparam int W_STOP  = 4;
  localparam int W_LINK  = 9;
  localparam int W_PCTL  = 13;

  // words carrying data; the rest of the node is reserved
  localparam logic [NODE_WORDS-1:0] USED_MASK = 16'hAEFB;

  localparam logic [7:0] OFS_NEXT   = 8'h24;
  localparam logic [7:0] OFS_STATUS = 8'h68;

  typedef struct packed {
    logic vsyncTick;   // a vsync edge this cycle
    logic startFetch;  // latch pointer, begin reading
    logic captureWord; // memRdata valid for current word
    logic lastWord;    // captured word is the final one
    logic discard;     // fetch made stale by a late vsync
    logic lateErr;     // vsync during fetch
    logic alignErr;    // vsync with misaligned pointer
  } strobe_t;
endpackage

// File: rtl/plane_node_ctrl.sv
`timescale 1ns/1ps
module plane_node_ctrl
  import plane_node_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             vsync,
  input  logic             memRvalid,
  input  logic             nextZero,
  input  logic             nextMisaligned,
  output logic             memReq,
  output logic [IDX_W-1:0] wordIdx,
  output strobe_t          st
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

  typedef enum logic {ST_IDLE, ST_FETCH} state_t;
  state_t state;
  logic   stale;

  assign memReq = (state == ST_FETCH);

  always_comb begin
    st           = '0;
    st.vsyncTick = vsync;
    if (vsync && state == ST_IDLE && !nextZero) begin
      if (nextMisaligned) st.alignErr   = 1'b1;
      else                st.startFetch = 1'b1;
    end
    if (vsync && state == ST_FETCH) st.lateErr = 1'b1;
    if (state == ST_FETCH && memRvalid) begin
      st.captureWord = 1'b1;
      st.lastWord    = (wordIdx == LAST_IDX);
      st.discard     = stale || vsync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      stale   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (st.startFetch) begin
          state   <= ST_FETCH;
          wordIdx <= '0;
          stale   <= 1'b0;
        end
        ST_FETCH: begin
          if (vsync) stale <= 1'b1;
          if (memRvalid) begin
            if (wordIdx == LAST_IDX) state <= ST_IDLE;
            else wordIdx <= wordIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  no_fetch_on_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vsync && state == ST_IDLE && nextZero) |=> !memReq);
  // R8
  no_fetch_on_misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vsync && state == ST_IDLE && nextMisaligned) |=> !memReq);
endmodule

// File: rtl/plane_node_dp.sv
`timescale 1ns/1ps
module plane_node_dp
  import plane_node_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [31:0]       memRdata,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              fieldTop,
  input  logic              underflow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              nextZero,
  output logic              nextMisaligned,
  output logic [31:0]       regRdata,
  output logic              planeShow,
  output logic [31:0]       actPixAddr,
  output logic [31:0]       actPitch,
  output logic [31:0]       actSize,
  output logic [31:0]       actOrigin,
  output logic [31:0]       actStop
);
  localparam int LAST = NODE_WORDS - 1;

  logic [31:0]       stageW [NODE_WORDS];
  logic [31:0]       actW   [NODE_WORDS];
  logic [31:0]       fullNode [NODE_WORDS];
  logic [ADDR_W-1:0] nextNode, baseAddr;
  logic              pendValid, loaded;
  logic [3:0]        status;   // {field, misalign, late, underflow}
  logic              commitNow, commitAct, commitPend, applyPend, waitBit;
  logic              nextWr, statWr;

  assign nextWr = regWr && regAddr == REG_AW'(OFS_NEXT);
  assign statWr = regWr && regAddr == REG_AW'(OFS_STATUS);

  always_comb begin
    for (int i = 0; i < NODE_WORDS; i++)
      fullNode[i] = (i == LAST) ? memRdata : stageW[i];
  end

  assign waitBit    = stageW[W_CTL][31];
  assign commitNow  = st.captureWord && st.lastWord && !st.discard;
  assign commitAct  = commitNow && !waitBit;
  assign commitPend = commitNow && waitBit;
  assign applyPend  = st.vsyncTick && pendValid;

  for (genvar i = 0; i < NODE_WORDS; i++) begin : g_word
    if (USED_MASK[i]) begin : g_kept
      logic [31:0] stg, pnd, cur;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stg <= '0;
          pnd <= '0;
          cur <= '0;
        end else begin
          if (st.captureWord && wordIdx == IDX_W'(i)) stg <= memRdata;
          if (commitPend) pnd <= fullNode[i];
          if (commitAct)      cur <= fullNode[i];
          else if (applyPend) cur <= pnd;
        end
      end
      assign stageW[i] = stg;
      assign actW[i]   = cur;
    end else begin : g_rsvd
      assign stageW[i] = '0;
      assign actW[i]   = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextNode  <= '0;
      baseAddr  <= '0;
      pendValid <= 1'b0;
      loaded    <= 1'b0;
      status    <= '0;
    end else begin
      if (nextWr)         nextNode <= regWdata[ADDR_W-1:0];
      else if (commitNow) nextNode <= fullNode[W_LINK][ADDR_W-1:0];
      if (st.startFetch) baseAddr <= nextNode;
      if (commitPend)                  pendValid <= 1'b1;
      else if (commitAct || applyPend) pendValid <= 1'b0;
      if (commitAct || applyPend) loaded <= 1'b1;
      status[0] <= underflow    || (status[0] && !(statWr && regWdata[0]));
      status[1] <= st.lateErr   || (status[1] && !(statWr && regWdata[1]));
      status[2] <= st.alignErr  || (status[2] && !(statWr && regWdata[2]));
      if (st.vsyncTick) status[3] <= fieldTop;
    end
  end

  assign memAddr        = baseAddr + ADDR_W'({wordIdx, 2'b00});
  assign nextZero       = (nextNode == '0);
  assign nextMisaligned = |nextNode[3:0];

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_AW'(OFS_NEXT))
      regRdata = 32'(nextNode);
    else if (regAddr == REG_AW'(OFS_STATUS))
      regRdata = {28'd0, status};
    else if (regAddr[REG_AW-1:6] == '0 && regAddr[1:0] == 2'b00 &&
             USED_MASK[regAddr[5:2]])
      regRdata = actW[regAddr[5:2]];
  end

  assign planeShow  = loaded && (actW[W_PCTL][1:0] == 2'b00);
  assign actPixAddr = actW[W_PIX];
  assign actPitch   = actW[W_PITCH];
  assign actSize    = actW[W_SIZE];
  assign actOrigin  = actW[W_ORG];
  assign actStop    = actW[W_STOP];

  // R3
  atomic_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actPixAddr) |-> $past(commitAct || applyPend));
  // R10
  late_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.lateErr |=> status[1]);
  // R8
  align_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.alignErr |=> status[2]);
  // R11
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> status[0]);
endmodule

// File: rtl/plane_node_loader.sv
`timescale 1ns/1ps
module plane_node_loader
  import plane_node_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              vsync,
  input  logic              fieldTop,
  input  logic              underflow,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRvalid,
  input  logic [31:0]       memRdata,
  output logic              planeShow,
  output logic [31:0]       actPixAddr,
  output logic [31:0]       actPitch,
  output logic [31:0]       actSize,
  output logic [31:0]       actOrigin,
  output logic [31:0]       actStop
);
  strobe_t          st;
  logic [IDX_W-1:0] wordIdx;
  logic             nextZero, nextMisaligned;

  plane_node_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .vsync(vsync), .memRvalid(memRvalid),
    .nextZero(nextZero), .nextMisaligned(nextMisaligned),
    .memReq(memReq), .wordIdx(wordIdx), .st(st)
  );

  plane_node_dp #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wordIdx(wordIdx), .memRdata(memRdata),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .fieldTop(fieldTop), .underflow(underflow), .memAddr(memAddr),
    .nextZero(nextZero), .nextMisaligned(nextMisaligned), .regRdata(regRdata),
    .planeShow(planeShow), .actPixAddr(actPixAddr), .actPitch(actPitch),
    .actSize(actSize), .actOrigin(actOrigin), .actStop(actStop)
  );

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memRvalid && wordIdx != IDX_W'(NODE_WORDS - 1))
      |=> memAddr == $past(memAddr) + ADDR_W'(4));
endmodule

// File: tb/tb_plane_node_loader.sv
`timescale 1ns/1ps
module tb_plane_node_loader;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        vsync = 1'b0, fieldTop = 1'b0, underflow = 1'b0;
  logic        memReq, memRvalid = 1'b0, planeShow;
  logic [31:0] memAddr, memRdata = '0;
  logic [31:0] actPixAddr, actPitch, actSize, actOrigin, actStop;

  always #2.5 clk = ~clk;

  plane_node_loader dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .vsync(vsync),
    .fieldTop(fieldTop), .underflow(underflow), .memReq(memReq),
    .memAddr(memAddr), .memRvalid(memRvalid), .memRdata(memRdata),
    .planeShow(planeShow), .actPixAddr(actPixAddr), .actPitch(actPitch),
    .actSize(actSize), .actOrigin(actOrigin), .actStop(actStop)
  );

  localparam logic [15:0] USED = 16'hAEFB;
  logic [31:0] bmem [256];
  int total = 0, bad = 0;
  bit done = 0;

  // memory responder and address monitor
  int latCnt = 0, latTgt = 0;
  int monIdx = 0, addrErr = 0, reqCycles = 0;
  logic [31:0] monBase = '0;
  always @(posedge clk) begin
    if (memReq) reqCycles <= reqCycles + 1;
    if (memReq && memRvalid) begin
      if (memAddr !== monBase + 32'(monIdx * 4)) addrErr <= addrErr + 1;
      monIdx <= monIdx + 1;
    end
    if (memRvalid) begin
      memRvalid <= 1'b0;
      latCnt    <= 0;
      latTgt    <= $urandom_range(0, 2);
    end else if (memReq) begin
      if (latCnt >= latTgt) begin
        memRvalid <= 1'b1;
        memRdata  <= bmem[memAddr[9:2]];
      end else latCnt <= latCnt + 1;
    end
  end

  // bench model of the requirements
  logic [31:0] expAct [16];
  logic [31:0] expPend [16];
  logic        expPendV = 0, expLoaded = 0;
  logic [31:0] expNext = '0;
  logic [3:0]  expStat = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic pulse(input bit top);
    @(negedge clk); vsync = 1; fieldTop = top;
    @(negedge clk); vsync = 0;
  endtask

  task automatic checkAll();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      if (USED[i] && i != 9) begin
        readReg(8'(i * 4), d);
        check($sformatf("R13 active word %0d", i), d, expAct[i]);
      end
    end
    readReg(8'h24, d);  check("R4 next-node", d, expNext);
    readReg(8'h68, d);  check("R12 status", d, {28'd0, expStat});
    check("R6 planeShow", {31'd0, planeShow},
          {31'd0, expLoaded && expAct[13][1:0] == 2'b00});
    check("R3 pitch port", actPitch, expAct[6]);
    check("R3 size port", actSize, expAct[7]);
    check("R3 origin port", actOrigin, expAct[3]);
    check("R3 stop port", actStop, expAct[4]);
  endtask

  task automatic doVsync(input bit top);
    logic [31:0] node [16];
    bit fetch = 0;
    if (expPendV) begin expAct = expPend; expLoaded = 1; expPendV = 0; end
    expStat[3] = top;
    monBase = expNext; monIdx = 0; addrErr = 0; reqCycles = 0;
    if (expNext != 0 && expNext[3:0] != 0) expStat[2] = 1;
    else if (expNext != 0) fetch = 1;
    pulse(top);
    if (fetch) begin
      repeat (2) @(negedge clk);
      check("R3 pixel addr mid-fetch", actPixAddr, expAct[5]);
    end
    repeat (100) @(negedge clk);
    if (fetch) begin
      for (int k = 0; k < 16; k++) node[k] = bmem[expNext[9:2] + 8'(k)];
      check("R2 word count", 32'(monIdx), 32'd16);
      check("R2 address order", 32'(addrErr), 32'd0);
      if (node[0][31]) begin expPend = node; expPendV = 1; end
      else begin expAct = node; expLoaded = 1; expPendV = 0; end
      expNext = node[9];
    end else begin
      check("R7/R8 no request", 32'(reqCycles), 32'd0);
    end
    checkAll();
  endtask

  task automatic buildPair(output logic [31:0] topAddr);
    int s = $urandom_range(1, 7) * 2;
    logic [31:0] a = 32'(s * 64), b = 32'((s + 1) * 64);
    for (int k = 0; k < 16; k++) begin
      bmem[s * 16 + k]       = $urandom;
      bmem[(s + 1) * 16 + k] = $urandom;
    end
    bmem[s * 16 + 9]        = b;
    bmem[(s + 1) * 16 + 9]  = a;
    bmem[s * 16][31]        = ($urandom_range(0, 2) == 0);
    bmem[(s + 1) * 16][31]  = ($urandom_range(0, 2) == 0);
    bmem[s * 16 + 13][1:0]       = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
    bmem[(s + 1) * 16 + 13][1:0] = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
    topAddr = a;
  endtask

  initial begin
    logic [31:0] d, topA;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) bmem[i] = '0;
    for (int i = 0; i < 16; i++) begin expAct[i] = '0; expPend[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 reset state
    checkAll();
    check("R1 memReq", {31'd0, memReq}, 32'd0);
    check("R1 pixel port", actPixAddr, 32'd0);

    // R7 zero pointer
    doVsync(1);

    // R8 misaligned pointer, then R11 clear
    writeReg(8'h24, 32'h0000_0104); expNext = 32'h104;
    doVsync(0);
    writeReg(8'h68, 32'h4); expStat[2] = 0;
    readReg(8'h68, d); check("R11 clear misalign", d, {28'd0, expStat});

    // R9/R4/R5 random linked pairs
    for (int it = 0; it < 6; it++) begin
      buildPair(topA);
      writeReg(8'h24, topA); expNext = topA;
      readReg(8'h24, d); check("R9 pointer write", d, topA);
      for (int v = 0; v < 4; v++) doVsync(v[0] == 0);
    end

    // R5 directed: deferred node applies only at next vsync
    buildPair(topA);
    bmem[topA[9:2]][31] = 1'b1;
    writeReg(8'h24, topA); expNext = topA;
    doVsync(1);
    check("R5 deferred pending", 32'(expPendV), 32'd1);
    doVsync(0);

    // R10 late vsync discards the running fetch
    pulse(1);
    if (expPendV) begin expAct = expPend; expLoaded = 1; expPendV = 0; end
    repeat (10) @(negedge clk);
    pulse(0);
    expStat[3] = 0; expStat[1] = 1;
    repeat (100) @(negedge clk);
    checkAll();

    // R11 underflow sticky, set beats clear, W1C
    @(negedge clk); underflow = 1; regWr = 1; regAddr = 8'h68; regWdata = 32'h3;
    @(negedge clk); underflow = 0; regWr = 0;
    expStat[1] = 0; expStat[0] = 1;
    readReg(8'h68, d); check("R11 set wins over clear", d, {28'd0, expStat});
    writeReg(8'h68, 32'h1); expStat[0] = 0;
    readReg(8'h68, d); check("R11 W1C underflow", d, {28'd0, expStat});

    // R13 reserved offsets
    readReg(8'h08, d); check("R13 reserved 0x08", d, 32'd0);
    readReg(8'h40, d); check("R13 unmapped 0x40", d, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL all-R watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule